// File: doc/BRIEF.md
# Initialization Block Fetch Engine

This block loads a controller's operating parameters from a parameter block in host memory. Software first programs the 32-bit start address of that block as two 16-bit halves, picks the descriptor-size mode and the interrupt enable in a config register, and then writes the init control bit. The engine acts as a bus master. It fetches the block in short read tenures of exactly two DWORDs each, releasing the request between tenures. In 32-bit descriptor mode the block is eight DWORDs long, which takes four tenures. In 16-bit descriptor mode it is six DWORDs long, which takes three tenures.

Each returned DWORD is decoded by its position, using the layout of the selected mode. The decoded values land in a mode word, the receive and transmit ring base addresses, and the two ring length codes. When the last word is stored, a done flag rises. A level interrupt follows the done flag only when the interrupt is enabled. A start bit may be written together with init, but the run output stays low until the fetch has completed.

Top module: `init_fetch_engine`

## Requirements
- R1: Register write port: address 1 holds the low 16 bits of the start address and address 2 holds the high 16 bits. The first tenure's read address equals {high, low}.
- R2: After reset, rd_req_o, busy_o, done_o, irq_o and run_o are all 0. No fetch begins until a write to address 0 with bit 0 (init) set. Writing the base or config registers alone, or writing start alone, issues no request.
- R3: rd_req_o is held until a cycle in which rd_gnt_i is high. It is low in the cycle after the grant. Each tenure then accepts exactly two words, one per cycle in which rd_valid_i is high.
- R4: Tenure k (counting from 0) reads at start address + 8*k. Config register (address 3) bit 0 = 1 selects 32-bit descriptor mode, which uses 4 tenures. Bit 0 = 0 selects 16-bit mode, which uses 3 tenures.
- R5: 32-bit layout. Word 0 gives mode_o = [15:0], rx_len_o = [23:20] and tx_len_o = [31:28]. Word 4 is rx_base_o and word 5 is tx_base_o. Words 1-3, 6 and 7 are skipped.
- R6: 16-bit layout. Word 0 gives mode_o = [15:0]. Word 4 gives rx_base_o = {8'h0, [23:0]} and rx_len_o = {1'b0, [31:29]}. Word 5 gives tx_base_o and tx_len_o in the same way.
- R7: done_o is set in the cycle after the last word is accepted. irq_o equals done_o when config bit 1 (interrupt enable) is 1, and is 0 otherwise. Writing address 0 with bit 3 set clears done_o and irq_o.
- R8: Address 0 bit 1 sets the start flag and bit 2 clears it. run_o is high only while start is set, a fetch has completed since the last init, and no fetch is in progress.
- R9: While busy_o is high, init writes and config writes are ignored. Base writes do not change the addresses of the fetch in progress. A new init clears done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 base low, 2 base high, 3 config |
| reg_wdata_i | input | 16 | Register write data |
| rd_req_o | output | 1 | Bus-master read request |
| rd_addr_o | output | 32 | Byte address of the current tenure's first DWORD |
| rd_gnt_i | input | 1 | Bus grant |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data |
| mode_o | output | 16 | Loaded mode word |
| rx_base_o | output | 32 | Receive ring base address |
| tx_base_o | output | 32 | Transmit ring base address |
| rx_len_o | output | 4 | Receive ring length code |
| tx_len_o | output | 4 | Transmit ring length code |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | Init-done flag |
| irq_o | output | 1 | Gated init-done interrupt |
| run_o | output | 1 | Normal operation permitted |

## Verification
The hardest situation to reach from the ports is a second init, a config flip and a base rewrite all landing while a fetch is still in flight. The bench gets there by having its memory responder withhold the grant. The request then stays pending while these writes are made. After the grant is released, the bench shows that exactly the original mode's tenure count was seen, at the original addresses, and that no second fetch followed. Other runs insert grant delays and gaps between valid beats, so that word positions are checked when beats do not arrive back to back.

// File: rtl/ife_pkg.sv
package ife_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} fsm_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_BLO  = 2'd1;
  localparam logic [1:0] REG_BHI  = 2'd2;
  localparam logic [1:0] REG_CFG  = 2'd3;

  localparam int CTRL_INIT  = 0;
  localparam int CTRL_START = 1;
  localparam int CTRL_STOP  = 2;
  localparam int CTRL_DCLR  = 3;
  localparam int CFG_WIDE   = 0;
  localparam int CFG_IEN    = 1;
endpackage

// File: rtl/ife_regs.sv
module ife_regs
  import ife_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic [2*HALF_W-1:0] base_o,
  output logic              wide_o,
  output logic              ien_o,
  output logic              start_o,
  output logic              init_o,
  output logic              dclr_o
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic wide_q, ien_q, start_q;
  logic ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == REG_CTRL);
  assign init_o  = ctrl_wr && wdata_i[CTRL_INIT];
  assign dclr_o  = ctrl_wr && wdata_i[CTRL_DCLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0; hi_q <= '0; wide_q <= 1'b0; ien_q <= 1'b0; start_q <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        REG_BLO: lo_q <= wdata_i;
        REG_BHI: hi_q <= wdata_i;
        REG_CFG: if (!busy_i) begin
          wide_q <= wdata_i[CFG_WIDE];
          ien_q  <= wdata_i[CFG_IEN];
        end
        default: begin
          // stop wins over start
          if (wdata_i[CTRL_STOP])       start_q <= 1'b0;
          else if (wdata_i[CTRL_START]) start_q <= 1'b1;
        end
      endcase
    end
  end

  assign base_o  = {hi_q, lo_q};
  assign wide_o  = wide_q;
  assign ien_o   = ien_q;
  assign start_o = start_q;
endmodule

// File: rtl/ife_seq.sv
module ife_seq
  import ife_pkg::*;
#(
  parameter int AW       = 32,
  parameter int BEATS    = 2,
  parameter int WIDE_T   = 4,
  parameter int NARROW_T = 3,
  localparam int TW      = $clog2(WIDE_T),
  localparam int BW      = $clog2(BEATS),
  localparam int IDXW    = TW + BW,
  localparam int STRIDE  = BEATS * 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          dclr_i,
  input  logic          wide_i,
  input  logic [AW-1:0] base_i,
  input  logic          gnt_i,
  input  logic          valid_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          loaded_o,
  output logic          word_we_o,
  output logic [IDXW-1:0] word_idx_o
);
  fsm_e state_q;
  logic [AW-1:0] base_q;
  logic [TW-1:0] ten_q, last_ten;
  logic [BW-1:0] beat_q;
  logic wide_q, done_q, loaded_q;
  logic last_beat, start_fetch;

  assign last_ten    = wide_q ? TW'(WIDE_T - 1) : TW'(NARROW_T - 1);
  assign last_beat   = (beat_q == BW'(BEATS - 1));
  assign start_fetch = init_i && (state_q == ST_IDLE);
  assign word_we_o   = (state_q == ST_XFER) && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; base_q <= '0; ten_q <= '0; beat_q <= '0;
      wide_q <= 1'b0; done_q <= 1'b0; loaded_q <= 1'b0;
    end else begin
      if (dclr_i) done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_fetch) begin
          state_q <= ST_REQ; base_q <= base_i; wide_q <= wide_i;
          ten_q <= '0; beat_q <= '0; done_q <= 1'b0; loaded_q <= 1'b0;
        end
        ST_REQ: if (gnt_i) state_q <= ST_XFER;
        ST_XFER: if (valid_i) begin
          if (last_beat) begin
            beat_q <= '0;
            if (ten_q == last_ten) begin
              state_q <= ST_IDLE; done_q <= 1'b1; loaded_q <= 1'b1;
            end else begin
              state_q <= ST_REQ; ten_q <= ten_q + TW'(1);
            end
          end else begin
            beat_q <= beat_q + BW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o      = (state_q == ST_REQ);
  assign addr_o     = base_q + AW'(ten_q) * AW'(STRIDE);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign loaded_o   = loaded_q;
  assign word_idx_o = {ten_q, beat_q};
endmodule

// File: rtl/ife_unpack.sv
module ife_unpack #(
  parameter int DW   = 32,
  parameter int IDXW = 3,
  parameter int MW   = 16,
  parameter int LW   = 4,
  parameter int NAW  = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            wide_i,
  input  logic [DW-1:0]   data_i,
  output logic [MW-1:0]   mode_o,
  output logic [DW-1:0]   rx_base_o,
  output logic [DW-1:0]   tx_base_o,
  output logic [LW-1:0]   rx_len_o,
  output logic [LW-1:0]   tx_len_o
);
  localparam int NLW = LW - 1;
  localparam logic [IDXW-1:0] IDX_MODE = IDXW'(0);
  localparam logic [IDXW-1:0] IDX_RX   = IDXW'(4);
  localparam logic [IDXW-1:0] IDX_TX   = IDXW'(5);

  logic [DW-1:0] n_base;
  logic [LW-1:0] n_len;
  assign n_base = DW'(data_i[NAW-1:0]);
  assign n_len  = LW'(data_i[DW-1 -: NLW]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0; rx_base_o <= '0; tx_base_o <= '0; rx_len_o <= '0; tx_len_o <= '0;
    end else if (we_i) begin
      case (idx_i)
        IDX_MODE: begin
          mode_o <= data_i[MW-1:0];
          if (wide_i) begin
            rx_len_o <= data_i[23:20];
            tx_len_o <= data_i[31:28];
          end
        end
        IDX_RX: begin
          rx_base_o <= wide_i ? data_i : n_base;
          if (!wide_i) rx_len_o <= n_len;
        end
        IDX_TX: begin
          tx_base_o <= wide_i ? data_i : n_base;
          if (!wide_i) tx_len_o <= n_len;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/init_fetch_engine.sv
module init_fetch_engine
  import ife_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int BEATS    = 2,
  parameter int WIDE_T   = 4,
  parameter int NARROW_T = 3,
  localparam int HALF_W  = AW / 2,
  localparam int IDXW    = $clog2(WIDE_T) + $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [HALF_W-1:0] reg_wdata_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_valid_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic [15:0]       mode_o,
  output logic [DW-1:0]     rx_base_o,
  output logic [DW-1:0]     tx_base_o,
  output logic [3:0]        rx_len_o,
  output logic [3:0]        tx_len_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              run_o
);
  logic [AW-1:0]   cfg_base;
  logic            cfg_wide, cfg_ien, start_q, init_pulse, dclr_pulse, loaded;
  logic            word_we;
  logic [IDXW-1:0] word_idx;

  ife_regs #(.HALF_W(HALF_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_o), .base_o(cfg_base), .wide_o(cfg_wide), .ien_o(cfg_ien),
    .start_o(start_q), .init_o(init_pulse), .dclr_o(dclr_pulse)
  );

  ife_seq #(.AW(AW), .BEATS(BEATS), .WIDE_T(WIDE_T), .NARROW_T(NARROW_T)) u_seq (
    .clk_i, .rst_ni, .init_i(init_pulse), .dclr_i(dclr_pulse), .wide_i(cfg_wide),
    .base_i(cfg_base), .gnt_i(rd_gnt_i), .valid_i(rd_valid_i), .req_o(rd_req_o),
    .addr_o(rd_addr_o), .busy_o(busy_o), .done_o(done_o), .loaded_o(loaded),
    .word_we_o(word_we), .word_idx_o(word_idx)
  );

  ife_unpack #(.DW(DW), .IDXW(IDXW)) u_unpack (
    .clk_i, .rst_ni, .we_i(word_we), .idx_i(word_idx), .wide_i(cfg_wide),
    .data_i(rd_data_i), .mode_o, .rx_base_o, .tx_base_o, .rx_len_o, .tx_len_o
  );

  assign irq_o = done_o && cfg_ien;
  assign run_o = start_q && loaded && !busy_o;
endmodule

// File: rtl/ife_chk.sv
module ife_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rd_req_o,
  input logic rd_gnt_i,
  input logic rd_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic irq_o,
  input logic run_o,
  input logic cfg_wide
);
  logic [3:0] gnt_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  gnt_cnt <= '0;
    else if (!busy_o)             gnt_cnt <= '0;
    else if (rd_req_o && rd_gnt_i) gnt_cnt <= gnt_cnt + 4'd1;
  end

  a_r3_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_gnt_i |=> rd_req_o);
  a_r3_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_gnt_i |=> !rd_req_o);
  a_r4_tenures: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> gnt_cnt == (cfg_wide ? 4'd4 : 4'd3));
  a_r7_done_after_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rd_valid_i) && $past(busy_o));
  a_r7_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
  a_r8_run_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> !busy_o);
  a_r9_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(cfg_wide));
endmodule

bind init_fetch_engine ife_chk u_chk (.*);

// File: tb/tb_init_fetch_engine.sv
`timescale 1ns/1ps
module tb_init_fetch_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0; logic [1:0] waddr = '0; logic [15:0] wdata = '0;
  logic rd_req, rd_gnt = 1'b0, rd_valid = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic [15:0] mode; logic [31:0] rx_base, tx_base; logic [3:0] rx_len, tx_len;
  logic busy, done, irq, run;

  int checks = 0, fails = 0, ten_cnt = 0, gnt_delay = 0, gap = 0;
  logic hold_gnt = 1'b0;
  logic [31:0] ten_addr [8];

  always #2.5 clk = ~clk;

  init_fetch_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(waddr), .reg_wdata_i(wdata),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_gnt_i(rd_gnt), .rd_valid_i(rd_valid),
    .rd_data_i(rd_data), .mode_o(mode), .rx_base_o(rx_base), .tx_base_o(tx_base),
    .rx_len_o(rx_len), .tx_len_o(tx_len), .busy_o(busy), .done_o(done), .irq_o(irq), .run_o(run)
  );

  function automatic logic [31:0] mw(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1F2E_3D4C;
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req && !hold_gnt) begin
        repeat (gnt_delay) @(negedge clk);
        rd_gnt = 1'b1;
        if (ten_cnt < 8) ten_addr[ten_cnt] = rd_addr;
        ten_cnt++;
        @(negedge clk);
        rd_gnt = 1'b0;
        for (int b = 0; b < 2; b++) begin
          if (gap > 0) begin rd_valid = 1'b0; repeat (gap) @(negedge clk); end
          rd_valid = 1'b1;
          rd_data = mw(ten_addr[(ten_cnt - 1) % 8] + 32'(4 * b));
          @(negedge clk);
        end
        rd_valid = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 reset req", 32'(rd_req), 0);
    chk("R2 reset busy", 32'(busy), 0);
    chk("R2 reset done", 32'(done), 0);
    chk("R2 reset irq", 32'(irq), 0);
    chk("R2 reset run", 32'(run), 0);
  endtask

  task automatic t_no_init();
    wr(2'd1, 16'h1000); wr(2'd2, 16'h0002); wr(2'd3, 16'h0003); wr(2'd0, 16'h0002);
    repeat (20) @(negedge clk);
    chk("R2 no fetch without init", 32'(ten_cnt), 0);
    chk("R2 no request without init", 32'(rd_req), 0);
    chk("R8 start alone gives no run", 32'(run), 0);
    wr(2'd0, 16'h0004);
  endtask

  task automatic expect_fields(input logic [31:0] b, input bit wide, input string tag);
    logic [31:0] w0, w4, w5;
    w0 = mw(b); w4 = mw(b + 32'd16); w5 = mw(b + 32'd20);
    chk({tag, " mode"}, 32'(mode), 32'(w0[15:0]));
    if (wide) begin
      chk({tag, " rx_len"}, 32'(rx_len), 32'(w0[23:20]));
      chk({tag, " tx_len"}, 32'(tx_len), 32'(w0[31:28]));
      chk({tag, " rx_base"}, rx_base, w4);
      chk({tag, " tx_base"}, tx_base, w5);
    end else begin
      chk({tag, " rx_len"}, 32'(rx_len), 32'(w4[31:29]));
      chk({tag, " tx_len"}, 32'(tx_len), 32'(w5[31:29]));
      chk({tag, " rx_base"}, rx_base, {8'h0, w4[23:0]});
      chk({tag, " tx_base"}, tx_base, {8'h0, w5[23:0]});
    end
  endtask

  task automatic t_fetch(input logic [31:0] b, input bit wide, input bit ien,
                         input int dly, input int gp, input string tag);
    int n;
    ten_cnt = 0; gnt_delay = dly; gap = gp;
    n = wide ? 4 : 3;
    wr(2'd1, b[15:0]); wr(2'd2, b[31:16]); wr(2'd3, {14'h0, ien, wide});
    wr(2'd0, 16'h0001);
    wait_done();
    @(negedge clk);
    chk({tag, " R4 tenure count"}, 32'(ten_cnt), 32'(n));
    chk({tag, " R1 first address"}, ten_addr[0], b);
    for (int k = 1; k < n; k++) chk({tag, " R4 tenure address"}, ten_addr[k], b + 32'(8 * k));
    chk({tag, " R7 done"}, 32'(done), 1);
    chk({tag, " R7 irq gate"}, 32'(irq), 32'(ien));
    chk({tag, " R3 request idle"}, 32'(rd_req), 0);
    expect_fields(b, wide, wide ? {tag, " R5"} : {tag, " R6"});
  endtask

  task automatic t_clear();
    wr(2'd0, 16'h0008);
    @(negedge clk);
    chk("R7 done cleared", 32'(done), 0);
    chk("R7 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_busy_ignore();
    ten_cnt = 0; gnt_delay = 0; gap = 0; hold_gnt = 1'b1;
    wr(2'd1, 16'h4440); wr(2'd2, 16'h0123); wr(2'd3, 16'h0001);
    wr(2'd0, 16'h0003);
    chk("R9 busy", 32'(busy), 1);
    chk("R9 init clears done", 32'(done), 0);
    chk("R8 no run while busy", 32'(run), 0);
    chk("R3 request held", 32'(rd_req), 1);
    wr(2'd3, 16'h0002); wr(2'd1, 16'h9990); wr(2'd0, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R3 request still held", 32'(rd_req), 1);
    hold_gnt = 1'b0;
    wait_done();
    repeat (30) @(negedge clk);
    chk("R9 single fetch of original mode", 32'(ten_cnt), 4);
    chk("R9 original base kept", ten_addr[3], 32'h0123_4458);
    chk("R9 ien write ignored", 32'(irq), 0);
    expect_fields(32'h0123_4440, 1'b1, "R9 R5");
    chk("R8 run after done", 32'(run), 1);
    wr(2'd0, 16'h0004);
    @(negedge clk);
    chk("R8 stop clears run", 32'(run), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_init();
    t_fetch(32'h8000_1230, 1'b1, 1'b1, 0, 0, "wide");
    t_clear();
    t_fetch(32'h0056_7F08, 1'b0, 1'b0, 2, 1, "narrow");
    t_fetch(32'hFFFF_FFE0, 1'b0, 1'b1, 1, 2, "narrow wrap");
    t_clear();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule